// File: doc/BRIEF.md
# Multi-Channel Elastic Link Receiver

This block terminates a point-to-point link on which several virtual channels share one flit bus. The sender presents one flit per cycle on the common data wires and marks its channel by raising exactly one of a set of per-channel valid lines. The receiver answers with one ready line per channel, and those lines are independent. Each channel owns a private first-in first-out buffer and a slot counter that tracks its free entries. The counter alone drives that channel's ready line, so a congested channel stalls only its own traffic.

On the far side, each channel offers its oldest flit through a show-ahead pop interface. Downstream logic may drain any number of channels in the same cycle. If the sender raises more than one valid line at once, that breaks the link protocol. The receiver then writes nothing and raises an error flag for that cycle. The channel count, flit width and buffer depth are all parameters.

Top module: `vc_link_rx`

## Requirements
- R1: After reset, every `in_ready` bit is 1, every `out_avail` bit is 0 and `proto_err` is 0.
- R2: When `in_valid[i]` and `in_ready[i]` are both 1 and no other valid bit is 1, `in_flit` is stored in channel i at the clock edge. Each channel presents its flits on `out_flit[i*FLIT_W +: FLIT_W]` in arrival order. `out_avail[i]` is 1 from the cycle after the store for as long as the channel holds a flit.
- R3: At most one channel buffer is written per cycle. A store into one channel leaves the contents and `out_avail` of every other channel unchanged.
- R4: `in_ready[i]` is 1 exactly when channel i holds fewer than DEPTH flits, and any number of ready bits may be 1 at once. A valid bit raised while its ready bit is 0 stores nothing.
- R5: `proto_err` is 1 in the same cycle that two or more `in_valid` bits are 1. In that cycle no flit is stored in any channel.
- R6: `out_pop[i]` removes the head flit of channel i when `out_avail[i]` is 1. Pops on several channels in the same cycle each take effect independently. A pop on an empty channel has no effect.
- R7: A store and a pop on the same channel in the same cycle leave that channel's occupancy, and so its `in_ready`, unchanged.
- R8: Filling one channel to DEPTH flits leaves the ready bits of the other channels at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_flit | input | FLIT_W | Shared link data bus |
| in_valid | input | NUM_VC | Per-channel valid, at most one expected high |
| in_ready | output | NUM_VC | Per-channel ready, high while the channel has a free slot |
| out_flit | output | NUM_VC*FLIT_W | Head flit of each channel, channel i in bits i*FLIT_W +: FLIT_W |
| out_avail | output | NUM_VC | Channel holds at least one flit |
| out_pop | input | NUM_VC | Remove head flit of the channel |
| proto_err | output | 1 | More than one valid bit high this cycle |

## Verification
A slot counter that drifts from the true occupancy shows up at the ports quickly. On the next cycle either `in_ready` no longer matches the number of stores minus pops, or `out_avail` stays high or low when it should not. A pointer fault shows as a wrong or out-of-order head flit on the first pop after it. The bench keeps a queue per channel and compares ready, availability, head flit and error flag every cycle, so any divergence is reported in the cycle it first becomes visible.

// File: rtl/vc_link_pkg.sv
package vc_link_pkg;

   function automatic int unsigned ptr_bits(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

   function automatic bit is_pow2(input int unsigned depth);
      return (depth > 1) && ((depth & (depth - 1)) == 0);
   endfunction

endpackage

// File: rtl/vc_link_valid_gate.sv
module vc_link_valid_gate #(
   parameter int unsigned NUM_VC = 3
) (
   input  logic [NUM_VC-1:0] valid,
   input  logic [NUM_VC-1:0] ready,
   output logic [NUM_VC-1:0] wr_en,
   output logic              multi
);
   logic [NUM_VC-1:0] low_cleared;

   always_comb begin
      low_cleared = valid & (valid - NUM_VC'(1));
      multi       = |low_cleared;
   end

   generate
      for (genvar g = 0; g < NUM_VC; g++) begin : g_gate
         assign wr_en[g] = valid[g] & ready[g] & ~multi;
      end
   endgenerate
endmodule

// File: rtl/vc_link_slot_ctr.sv
module vc_link_slot_ctr #(
   parameter int unsigned DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic pop_req,
   output logic pop_ok,
   output logic ready,
   output logic avail
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL_FREE = CNT_W'(DEPTH);

   logic [CNT_W-1:0] free_q;
   logic [CNT_W-1:0] free_d;

   assign ready  = (free_q != '0);
   assign avail  = (free_q != FULL_FREE);
   assign pop_ok = pop_req & avail;

   always_comb begin
      free_d = free_q;
      unique case ({wr_en, pop_ok})
         2'b10:   free_d = free_q - CNT_W'(1);
         2'b01:   free_d = free_q + CNT_W'(1);
         default: free_d = free_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) free_q <= FULL_FREE;
      else        free_q <= free_d;
   end
endmodule

// File: rtl/vc_link_fifo.sv
module vc_link_fifo
   import vc_link_pkg::*;
#(
   parameter int unsigned FLIT_W = 32,
   parameter int unsigned DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [FLIT_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [FLIT_W-1:0] rd_data
);
   localparam int unsigned PTR_W = ptr_bits(DEPTH);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [FLIT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr;
   logic [PTR_W-1:0]  rd_ptr;
   logic [PTR_W-1:0]  wr_ptr_nx;
   logic [PTR_W-1:0]  rd_ptr_nx;

   generate
      if (is_pow2(DEPTH)) begin : g_wrap_free
         assign wr_ptr_nx = wr_ptr + PTR_W'(1);
         assign rd_ptr_nx = rd_ptr + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wr_ptr_nx = (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_ptr_nx = (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr_nx;
         if (rd_en) rd_ptr <= rd_ptr_nx;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/vc_link_rx.sv
module vc_link_rx #(
   parameter int unsigned NUM_VC = 3,
   parameter int unsigned FLIT_W = 32,
   parameter int unsigned DEPTH  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [FLIT_W-1:0]        in_flit,
   input  logic [NUM_VC-1:0]        in_valid,
   output logic [NUM_VC-1:0]        in_ready,
   output logic [NUM_VC*FLIT_W-1:0] out_flit,
   output logic [NUM_VC-1:0]        out_avail,
   input  logic [NUM_VC-1:0]        out_pop,
   output logic                     proto_err
);
   generate
      if (NUM_VC < 1) begin : g_bad_vc
         $error("vc_link_rx: NUM_VC must be at least 1");
      end
      if (FLIT_W < 1) begin : g_bad_w
         $error("vc_link_rx: FLIT_W must be at least 1");
      end
      if (DEPTH < 1) begin : g_bad_d
         $error("vc_link_rx: DEPTH must be at least 1");
      end
   endgenerate

   logic [NUM_VC-1:0] wr_en;
   logic [NUM_VC-1:0] pop_ok;

   vc_link_valid_gate #(.NUM_VC(NUM_VC)) u_gate (
      .valid (in_valid),
      .ready (in_ready),
      .wr_en (wr_en),
      .multi (proto_err)
   );

   generate
      for (genvar v = 0; v < NUM_VC; v++) begin : g_lane
         vc_link_slot_ctr #(.DEPTH(DEPTH)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[v]),
            .pop_req (out_pop[v]),
            .pop_ok  (pop_ok[v]),
            .ready   (in_ready[v]),
            .avail   (out_avail[v])
         );

         vc_link_fifo #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[v]),
            .wr_data (in_flit),
            .rd_en   (pop_ok[v]),
            .rd_data (out_flit[v*FLIT_W +: FLIT_W])
         );
      end
   endgenerate
endmodule

// File: rtl/vc_link_rx_chk.sv
module vc_link_rx_chk #(
   parameter int unsigned NUM_VC = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_VC-1:0] in_ready,
   input logic [NUM_VC-1:0] out_avail,
   input logic              proto_err,
   input logic [NUM_VC-1:0] wr_en,
   input logic [NUM_VC-1:0] pop_ok
);
   p_one_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en));

   p_err_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> (wr_en == '0));

   p_write_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en & ~in_ready) == '0);

   generate
      for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
         p_avail_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[v] |=> out_avail[v]);

         p_pop_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_ok[v] && !wr_en[v]) |=> in_ready[v]);

         p_both_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_ok[v] && wr_en[v]) |=> ($stable(in_ready[v]) && out_avail[v]));
      end
   endgenerate
endmodule

bind vc_link_rx vc_link_rx_chk #(.NUM_VC(NUM_VC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_avail (out_avail),
   .proto_err (proto_err),
   .wr_en     (wr_en),
   .pop_ok    (pop_ok)
);

// File: tb/tb_vc_link_rx.sv
`timescale 1ns/1ps
module tb_vc_link_rx;
   localparam int NV = 3;
   localparam int FW = 16;
   localparam int DP = 4;
   localparam time CYC = 8ns;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [FW-1:0]    in_flit;
   logic [NV-1:0]    in_valid;
   logic [NV-1:0]    in_ready;
   logic [NV*FW-1:0] out_flit;
   logic [NV-1:0]    out_avail;
   logic [NV-1:0]    out_pop;
   logic             proto_err;

   int checks = 0;
   int errors = 0;
   logic [FW-1:0] q [NV][$];
   logic [FW-1:0] seq = 16'h0100;

   always #(CYC/2) clk = ~clk;

   vc_link_rx #(.NUM_VC(NV), .FLIT_W(FW), .DEPTH(DP)) dut (
      .clk(clk), .rst_n(rst_n), .in_flit(in_flit), .in_valid(in_valid),
      .in_ready(in_ready), .out_flit(out_flit), .out_avail(out_avail),
      .out_pop(out_pop), .proto_err(proto_err)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare(input logic [NV-1:0] v);
      for (int i = 0; i < NV; i++) begin
         chk(in_ready[i] == (q[i].size() < DP), "R4 ready", in_ready[i], q[i].size() < DP);
         chk(out_avail[i] == (q[i].size() > 0), "R2/R3/R6 avail", out_avail[i], q[i].size() > 0);
         if (q[i].size() > 0)
            chk(out_flit[i*FW +: FW] == q[i][0], "R2 head", out_flit[i*FW +: FW], q[i][0]);
      end
      chk(proto_err == ($countones(v) > 1), "R5 err", proto_err, $countones(v) > 1);
   endtask

   task automatic step(input logic [NV-1:0] v, input logic [NV-1:0] p);
      @(negedge clk);
      in_valid = v;
      in_flit  = seq;
      out_pop  = p;
      #1;
      compare(v);
      for (int i = 0; i < NV; i++) begin
         bit acc;
         acc = v[i] && ($countones(v) == 1) && (q[i].size() < DP);
         if (p[i] && q[i].size() > 0) void'(q[i].pop_front());
         if (acc) q[i].push_back(seq);
      end
      seq = seq + 16'h0013;
   endtask

   function automatic logic [NV-1:0] pick_valid(input int pct_on, input int pct_multi);
      logic [NV-1:0] r;
      r = '0;
      if (int'($urandom_range(99)) < pct_multi) r = NV'($urandom);
      else if (int'($urandom_range(99)) < pct_on) r[$urandom_range(NV-1)] = 1'b1;
      return r;
   endfunction

   initial begin
      #(CYC * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = '0; in_flit = '0; out_pop = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1: reset state
      chk(in_ready == '1, "R1 ready", in_ready, '1);
      chk(out_avail == '0, "R1 avail", out_avail, 0);
      chk(proto_err == 1'b0, "R1 err", proto_err, 0);

      // R8: fill channel 0 only, others stay ready
      for (int k = 0; k < DP + 2; k++) step(3'b001, '0);
      step('0, '0);
      chk(in_ready[0] == 1'b0, "R4 full channel not ready", in_ready[0], 0);
      chk(in_ready[2:1] == 2'b11, "R8 other channels ready", in_ready[2:1], 3);

      // R7: drop to DEPTH-1, then store and pop together
      step('0, 3'b001);
      step(3'b001, 3'b001);
      step('0, '0);
      chk(in_ready[0] == 1'b1, "R7 occupancy kept", in_ready[0], 1);

      // R5: multi-valid stores nothing
      step(3'b110, '0);
      step('0, '0);
      chk(out_avail[2:1] == 2'b00, "R5 no store on multi", out_avail[2:1], 0);

      // R6: pop on empty channel ignored, simultaneous pops
      step('0, 3'b110);
      step(3'b010, '0);
      step(3'b100, '0);
      step('0, 3'b111);

      // random phases
      for (int k = 0; k < 1500; k++) step(pick_valid(70, 3), NV'($urandom));
      for (int k = 0; k < 600; k++)  step(pick_valid(95, 0), NV'($urandom_range(1) ? 0 : $urandom));
      for (int k = 0; k < 400; k++)  step(pick_valid(80, 40), NV'($urandom));
      for (int k = 0; k < 400; k++)  step(pick_valid(60, 2), '1);
      for (int k = 0; k < 20; k++)   step('0, '1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule